// File: doc/BRIEF.md
# Transactional Undo Log Writer

This block performs eager version management for a single processor that runs hardware transactions. It keeps a small line-granular cache model together with a read bit and a write bit for each line. It also holds a log base register, a log pointer and a nesting depth counter. The first transactional store to a line copies the line's current contents into a linear undo log before the new data overwrites the line in place. A commit therefore copies no data: it only clears the tracking bits and moves the pointer back to the base.

An abort reads the log back from the newest record to the oldest. Each old line image is written into the cache model and also leaves through the memory-write port. Once the last record has been restored, the tracking state is cleared. Log records go out through the same write port, and a flag separates them from line restores. The log is read back through an asynchronous read port: the record at `log_rd_addr` must be present on `log_rd_rec` in any cycle in which `log_rd_en` is high.

Commands arrive one per cycle on `op_valid`/`op_kind`. The codes are: 1 load, 2 store, 3 begin, 4 commit, 5 abort. Code 0 and codes 6 and 7 do nothing.

Top module: `tx_undo_log`

## Requirements
- R1: After a synchronous reset, `busy`, `tx_depth`, `log_ptr`, `rd_bits`, `wr_bits`, `mem_we` and `log_rd_en` are all zero.
- R2: A begin at depth 0 loads both the base and `log_ptr` from `cfg_log_base` and sets the depth to 1. A begin at a nonzero depth only adds one to the depth.
- R3: A load returns the whole line in `ld_data` one cycle after it is accepted. The line index is taken from address bits [8:6]. A load at a nonzero depth sets that line's bit in `rd_bits`, and a load at depth 0 sets no bit.
- R4: A store at a nonzero depth to a line whose write bit is clear does the following. It sets the write bit. In the next cycle it raises `busy` and `mem_we` with `mem_wlog`=1, and writes a record at the old `log_ptr`. The record's bits [63:0] hold the line-aligned address and its bits [575:64] hold the old line. `log_ptr` moves forward by 0x48, and the line holds the new data from then on.
- R5: A store at a nonzero depth to a line whose write bit is already set writes no record and leaves `log_ptr` unchanged. It still updates the line in place.
- R6: A commit at depth 1 clears all read and write bits, sets `log_ptr` back to the base and sets the depth to 0, and the stored data stays as it is. A commit at a depth above 1 only takes one from the depth.
- R7: An abort at a nonzero depth reads the records from the newest to the oldest, one per cycle. For each record it writes the old data back into its line and emits `mem_we` with `mem_wlog`=0, with `mem_waddr` set to the line address and `mem_wdata` set to the record. It then clears the bits, sets the depth to 0 and sets `log_ptr` back to the base.
- R8: An abort with an empty log clears the bits and the depth in the cycle it is accepted and makes no memory write.
- R9: While `busy` is high, every presented command is dropped.
- R10: At depth 0, a store updates the line in place and creates neither a log record nor a tracking bit. A commit or an abort at depth 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Command present |
| op_kind | input | 3 | Command code (1 load, 2 store, 3 begin, 4 commit, 5 abort) |
| op_addr | input | 32 | Byte address of the line |
| op_data | input | 512 | New line contents for a store |
| cfg_log_base | input | 32 | Log base, taken by an outermost begin |
| busy | output | 1 | Log write or replay in progress |
| ld_data | output | 512 | Line returned by a load |
| rd_bits | output | 8 | Read bit of each line |
| wr_bits | output | 8 | Write bit of each line |
| tx_depth | output | 4 | Nesting depth |
| log_ptr | output | 32 | Next free log byte |
| mem_we | output | 1 | Memory write strobe |
| mem_wlog | output | 1 | 1: log record, 0: line restore |
| mem_waddr | output | 32 | Write address |
| mem_wdata | output | 576 | Record (address in the low 64 bits, line image above) |
| log_rd_en | output | 1 | Log read request |
| log_rd_addr | output | 32 | Address of the record to read |
| log_rd_rec | input | 576 | Record at `log_rd_addr`, same cycle |

## Verification
The hardest state to reach is a replay of several records whose line images differ from the lines' current contents. In that state, the order of the restores and the final contents of each line can both be told apart. To build it, the bench first fills the lines with known values using stores at depth 0. It then opens a transaction and logs three lines in an order that does not match their addresses. It rewrites one logged line a second time, which adds no record, and then aborts. The bench's log memory serves the read port from the records it captured on the write port. The bench then checks the sequence of restore addresses, the number of busy cycles and the contents of every line that was touched.

// File: rtl/tx_undo_log.sv
module tx_undo_log #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int AFLD_BYTES = 8,
  parameter int NLINES     = 8,
  parameter int DEPTH_W    = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     op_valid,
  input  logic [2:0]               op_kind,
  input  logic [ADDR_W-1:0]        op_addr,
  input  logic [LINE_BYTES*8-1:0]  op_data,
  input  logic [ADDR_W-1:0]        cfg_log_base,
  output logic                     busy,
  output logic [LINE_BYTES*8-1:0]  ld_data,
  output logic [NLINES-1:0]        rd_bits,
  output logic [NLINES-1:0]        wr_bits,
  output logic [DEPTH_W-1:0]       tx_depth,
  output logic [ADDR_W-1:0]        log_ptr,
  output logic                     mem_we,
  output logic                     mem_wlog,
  output logic [ADDR_W-1:0]        mem_waddr,
  output logic [(LINE_BYTES+AFLD_BYTES)*8-1:0] mem_wdata,
  output logic                     log_rd_en,
  output logic [ADDR_W-1:0]        log_rd_addr,
  input  logic [(LINE_BYTES+AFLD_BYTES)*8-1:0] log_rd_rec
);
  localparam int LINE_W    = LINE_BYTES * 8;
  localparam int AF_W      = AFLD_BYTES * 8;
  localparam int REC_W     = AF_W + LINE_W;
  localparam int REC_BYTES = LINE_BYTES + AFLD_BYTES;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int IDX_W     = $clog2(NLINES);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(LINE_BYTES - 1);

  localparam logic [2:0] K_LOAD = 3'd1, K_STORE = 3'd2, K_BEGIN = 3'd3,
                         K_COMMIT = 3'd4, K_ABORT = 3'd5;

  typedef enum logic [1:0] {ST_IDLE, ST_LOGW, ST_REPLAY} state_t;

  state_t                state;
  logic [LINE_W-1:0]     lines [NLINES];
  logic [ADDR_W-1:0]     base_q;
  logic [IDX_W-1:0]      pend_idx;
  logic [LINE_W-1:0]     pend_data;

  logic [IDX_W-1:0]      idx, rec_idx;
  logic [ADDR_W-1:0]     line_addr, prev_ptr;
  logic                  in_tx, accept, log_empty;

  assign idx       = op_addr[OFF_W +: IDX_W];
  assign line_addr = op_addr & ~OFF_MASK;
  assign rec_idx   = log_rd_rec[OFF_W +: IDX_W];
  assign prev_ptr  = log_ptr - ADDR_W'(REC_BYTES);
  assign in_tx     = tx_depth != '0;
  assign accept    = op_valid && state == ST_IDLE;
  assign log_empty = log_ptr == base_q;
  assign busy      = state != ST_IDLE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      for (int i = 0; i < NLINES; i++) lines[i] <= '0;
      base_q      <= '0;
      log_ptr     <= '0;
      tx_depth    <= '0;
      rd_bits     <= '0;
      wr_bits     <= '0;
      ld_data     <= '0;
      pend_idx    <= '0;
      pend_data   <= '0;
      mem_we      <= 1'b0;
      mem_wlog    <= 1'b0;
      mem_waddr   <= '0;
      mem_wdata   <= '0;
      log_rd_en   <= 1'b0;
      log_rd_addr <= '0;
    end else begin
      mem_we   <= 1'b0;
      mem_wlog <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          case (op_kind)
            K_LOAD: begin
              ld_data <= lines[idx];
              if (in_tx) rd_bits[idx] <= 1'b1;
            end
            K_STORE: begin
              if (in_tx && !wr_bits[idx]) begin
                wr_bits[idx] <= 1'b1;
                mem_we       <= 1'b1;
                mem_wlog     <= 1'b1;
                mem_waddr    <= log_ptr;
                mem_wdata    <= {lines[idx], {(AF_W-ADDR_W){1'b0}}, line_addr};
                log_ptr      <= log_ptr + ADDR_W'(REC_BYTES);
                pend_idx     <= idx;
                pend_data    <= op_data;
                state        <= ST_LOGW;
              end else begin
                lines[idx] <= op_data;
              end
            end
            K_BEGIN: begin
              if (!in_tx) begin
                base_q  <= cfg_log_base;
                log_ptr <= cfg_log_base;
              end
              if (tx_depth != '1) tx_depth <= tx_depth + 1'b1;
            end
            K_COMMIT: begin
              if (tx_depth == DEPTH_W'(1)) begin
                rd_bits  <= '0;
                wr_bits  <= '0;
                tx_depth <= '0;
                log_ptr  <= base_q;
              end else if (in_tx) begin
                tx_depth <= tx_depth - 1'b1;
              end
            end
            K_ABORT: begin
              if (in_tx) begin
                if (log_empty) begin
                  rd_bits  <= '0;
                  wr_bits  <= '0;
                  tx_depth <= '0;
                end else begin
                  log_rd_en   <= 1'b1;
                  log_rd_addr <= prev_ptr;
                  log_ptr     <= prev_ptr;
                  state       <= ST_REPLAY;
                end
              end
            end
            default: ;
          endcase
        end
        ST_LOGW: begin
          lines[pend_idx] <= pend_data;
          state           <= ST_IDLE;
        end
        ST_REPLAY: begin
          lines[rec_idx] <= log_rd_rec[REC_W-1:AF_W];
          mem_we         <= 1'b1;
          mem_waddr      <= log_rd_rec[ADDR_W-1:0];
          mem_wdata      <= log_rd_rec;
          if (log_empty) begin
            log_rd_en <= 1'b0;
            rd_bits   <= '0;
            wr_bits   <= '0;
            tx_depth  <= '0;
            state     <= ST_IDLE;
          end else begin
            log_rd_addr <= prev_ptr;
            log_ptr     <= prev_ptr;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_rec_step_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mem_wlog) |-> (busy && log_ptr == mem_waddr + ADDR_W'(REC_BYTES)));

  assert_wbit_rise_R4: assert property (@(posedge clk) disable iff (rst)
    ((wr_bits & ~$past(wr_bits)) != '0) |-> (mem_we && mem_wlog));

  assert_idle_clean_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_depth == '0) |-> (wr_bits == '0 && rd_bits == '0 && log_ptr == base_q && !log_rd_en));

  assert_ptr_floor_R2: assert property (@(posedge clk) disable iff (rst)
    (tx_depth != '0) |-> (log_ptr >= base_q));

  assert_replay_order_R7: assert property (@(posedge clk) disable iff (rst)
    (log_rd_en && $past(log_rd_en)) |-> (log_rd_addr == $past(log_rd_addr) - ADDR_W'(REC_BYTES)));

  assert_rec_aligned_R7: assert property (@(posedge clk) disable iff (rst)
    log_rd_en |-> (log_rd_rec[AF_W-1:ADDR_W] == '0 && log_rd_rec[OFF_W-1:0] == '0));

  assert_replay_busy_R9: assert property (@(posedge clk) disable iff (rst)
    log_rd_en |-> busy);
endmodule

// File: tb/tx_undo_log_test.sv
module tx_undo_log_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         op_valid = 1'b0;
  logic [2:0]   op_kind  = '0;
  logic [31:0]  op_addr  = '0;
  logic [511:0] op_data  = '0;
  logic [31:0]  cfg_log_base = '0;
  logic         busy;
  logic [511:0] ld_data;
  logic [7:0]   rd_bits, wr_bits;
  logic [3:0]   tx_depth;
  logic [31:0]  log_ptr;
  logic         mem_we, mem_wlog;
  logic [31:0]  mem_waddr;
  logic [575:0] mem_wdata;
  logic         log_rd_en;
  logic [31:0]  log_rd_addr;
  logic [575:0] log_rd_rec;

  tx_undo_log uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr),
    .op_data(op_data), .cfg_log_base(cfg_log_base), .busy(busy), .ld_data(ld_data),
    .rd_bits(rd_bits), .wr_bits(wr_bits), .tx_depth(tx_depth), .log_ptr(log_ptr),
    .mem_we(mem_we), .mem_wlog(mem_wlog), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .log_rd_en(log_rd_en), .log_rd_addr(log_rd_addr), .log_rd_rec(log_rd_rec));

  int checks = 0;
  int fails  = 0;
  logic [575:0] bmem [16];
  logic [31:0]  bbase = '0;
  logic [31:0]  rest_addr [16];
  int nlog  = 0;
  int nrest = 0;

  function automatic logic [511:0] pat(input logic [31:0] v);
    return {16{v}};
  endfunction

  function automatic int slot(input logic [31:0] a);
    return int'(((a - bbase) / 32'd72) % 32'd16);
  endfunction

  assign log_rd_rec = bmem[slot(log_rd_addr)];

  always @(posedge clk) begin
    if (!rst && mem_we) begin
      if (mem_wlog) begin
        bmem[slot(mem_waddr)] <= mem_wdata;
        nlog <= nlog + 1;
      end else begin
        rest_addr[nrest % 16] <= mem_waddr;
        nrest <= nrest + 1;
      end
    end
  end

  task automatic chk(input string req, input logic [575:0] act, input logic [575:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] k, input logic [31:0] a, input logic [511:0] d);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_addr = a; op_data = d;
    @(negedge clk);
    op_valid = 1'b0; op_kind = 3'd0;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 busy", busy, 0);
    chk("R1 depth", tx_depth, 0);
    chk("R1 ptr", log_ptr, 0);
    chk("R1 bits", {rd_bits, wr_bits}, 0);
    chk("R1 we", {mem_we, log_rd_en}, 0);
  endtask

  task automatic t_plain();
    for (int i = 0; i < 4; i++) do_op(3'd2, 32'(i * 64), pat(32'h10 + 32'(i)));
    @(negedge clk);
    chk("R10 no record", nlog, 0);
    chk("R10 no wbits", wr_bits, 0);
    do_op(3'd1, 32'h80, '0);
    chk("R3 plain load data", ld_data, pat(32'h12));
    chk("R3 plain load no rbit", rd_bits, 0);
    do_op(3'd5, 32'h0, '0);
    chk("R10 abort at depth0", {busy, tx_depth}, 0);
    do_op(3'd4, 32'h0, '0);
    chk("R10 commit at depth0", tx_depth, 0);
  endtask

  task automatic t_nest_commit();
    cfg_log_base = 32'h1000; bbase = 32'h1000;
    do_op(3'd3, 0, '0);
    chk("R2 outer begin depth", tx_depth, 1);
    chk("R2 outer begin ptr", log_ptr, 32'h1000);
    cfg_log_base = 32'h3000;
    do_op(3'd3, 0, '0);
    chk("R2 nested depth", tx_depth, 2);
    chk("R2 nested ptr kept", log_ptr, 32'h1000);
    do_op(3'd1, 32'h40, '0);
    chk("R3 tx load data", ld_data, pat(32'h11));
    chk("R3 tx load rbit", rd_bits, 8'h02);
    do_op(3'd2, 32'hC4, pat(32'h56));
    chk("R4 busy", busy, 1);
    chk("R4 strobe", {mem_we, mem_wlog}, 2'b11);
    chk("R4 log addr", mem_waddr, 32'h1000);
    chk("R4 record", mem_wdata, {pat(32'h13), 64'hC0});
    chk("R4 ptr step", log_ptr, 32'h1048);
    chk("R4 wbit", wr_bits, 8'h08);
    settle();
    do_op(3'd1, 32'hC0, '0);
    chk("R4 in place", ld_data, pat(32'h56));
    do_op(3'd2, 32'hC0, pat(32'h57));
    chk("R5 no strobe", {busy, mem_we}, 0);
    chk("R5 ptr kept", log_ptr, 32'h1048);
    @(negedge clk);
    chk("R5 one record", nlog, 1);
    do_op(3'd1, 32'hC0, '0);
    chk("R5 data", ld_data, pat(32'h57));
    do_op(3'd4, 0, '0);
    chk("R6 nested commit depth", tx_depth, 1);
    chk("R6 nested commit keeps bits", wr_bits, 8'h08);
    chk("R6 nested commit ptr", log_ptr, 32'h1048);
    do_op(3'd4, 0, '0);
    chk("R6 commit depth", tx_depth, 0);
    chk("R6 commit bits", {rd_bits, wr_bits}, 0);
    chk("R6 commit ptr", log_ptr, 32'h1000);
    do_op(3'd1, 32'hC0, '0);
    chk("R6 commit keeps data", ld_data, pat(32'h57));
  endtask

  task automatic t_abort_replay();
    int n0, r0, bc;
    cfg_log_base = 32'h2000; bbase = 32'h2000;
    do_op(3'd3, 0, '0);
    chk("R2 reload base", log_ptr, 32'h2000);
    n0 = nlog; r0 = nrest;
    do_op(3'd2, 32'h40, pat(32'hA1)); settle();
    do_op(3'd2, 32'h80, pat(32'hA2)); settle();
    do_op(3'd2, 32'h00, pat(32'hA0)); settle();
    do_op(3'd2, 32'h40, pat(32'hA3)); settle();
    chk("R4 three records", nlog - n0, 3);
    chk("R4 ptr three", log_ptr, 32'h20D8);
    do_op(3'd5, 0, '0);
    bc = 0;
    while (busy && bc < 20) begin bc++; @(negedge clk); end
    @(negedge clk);
    chk("R7 one record per cycle", bc, 3);
    chk("R7 restore count", nrest - r0, 3);
    chk("R7 newest first", rest_addr[r0 % 16], 32'h00);
    chk("R7 middle", rest_addr[(r0 + 1) % 16], 32'h80);
    chk("R7 oldest last", rest_addr[(r0 + 2) % 16], 32'h40);
    chk("R7 cleared", {tx_depth, rd_bits, wr_bits}, 0);
    chk("R7 ptr base", log_ptr, 32'h2000);
    do_op(3'd1, 32'h00, '0); chk("R7 line0", ld_data, pat(32'h10));
    do_op(3'd1, 32'h40, '0); chk("R7 line1", ld_data, pat(32'h11));
    do_op(3'd1, 32'h80, '0); chk("R7 line2", ld_data, pat(32'h12));
  endtask

  task automatic t_abort_empty();
    int r0;
    r0 = nrest;
    do_op(3'd3, 0, '0);
    do_op(3'd1, 32'h40, '0);
    chk("R3 rbit before abort", rd_bits, 8'h02);
    do_op(3'd5, 0, '0);
    chk("R8 no busy", busy, 0);
    chk("R8 cleared", {tx_depth, rd_bits, wr_bits}, 0);
    @(negedge clk); @(negedge clk);
    chk("R8 no writes", nrest - r0, 0);
  endtask

  task automatic t_busy_drop();
    do_op(3'd3, 0, '0);
    @(negedge clk);
    op_valid = 1'b1; op_kind = 3'd2; op_addr = 32'h80; op_data = pat(32'hB2);
    @(negedge clk);
    op_addr = 32'h40; op_data = pat(32'hB1);
    chk("R9 busy seen", busy, 1);
    @(negedge clk);
    op_valid = 1'b0; op_kind = 3'd0;
    chk("R9 dropped wbit", wr_bits, 8'h04);
    do_op(3'd1, 32'h40, '0);
    chk("R9 dropped data", ld_data, pat(32'h11));
    do_op(3'd4, 0, '0);
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) bmem[i] = '0;
    t_reset();
    t_plain();
    t_nest_commit();
    t_abort_replay();
    t_abort_empty();
    t_busy_drop();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule